// File: doc/BRIEF.md
# SDRAM Suspend Refresh Controller

This block owns the clock-enable lines of a memory controller for up to six rows. It puts the rows into self-refresh when the system suspends and brings them back on resume. While the system runs, it can also drop CKE on rows that sit idle, which is dynamic power-down. Two strap-style configuration bits select the board topology. One topology drives one CKE pin per row. Another drives only pin 0 as a shared CKE. The third drives only pin 0 as a global enable that external logic fans out to the rows. The topology also decides whether rows enter self-refresh one after another or all at once, and whether power-down is allowed.

Self-refresh through CKE is skipped in two cases. The first is a registered-module flag, because stacked devices share CKE across logical rows. The second is the EDO refresh-type bit selecting CAS-before-RAS refresh. In both cases CKE stays high, no self-refresh command is issued, and suspend completes at once. On resume, every CKE rises together. A fixed exit wait then has to pass before the ready status comes back.

Top module: `sdram_suspend_ctl`

## Requirements
- R1: Reset state: every used CKE pin is high, `ready_o` is 1, `suspend_done_o` is 0 and `sr_cmd_o` is 0.
- R2: Per-row mode (`map_cfg_i`=0, `pwr_cfg_i`=0): a suspend request sampled at edge k drops CKE of row 0 after edge k+1. It then drops each next row in ascending order, N edges apart, where N is `stagger_gap_i` and a value of 0 counts as 1. `cke_o[r]` carries row r.
- R3: Single-CKE mode (`map_cfg_i`=1, `pwr_cfg_i` ignored): only `cke_o[0]` is used and pins 1..5 are held 0. All rows receive their self-refresh command in one cycle, one edge after the request is sampled.
- R4: Global-CKE mode (`map_cfg_i`=0, `pwr_cfg_i`=1): only `cke_o[0]` is used and is high while any row is awake. Pins 1..5 are held 0. Entry is staggered as in R2.
- R5: `suspend_done_o` rises one edge after the last row has entered self-refresh and stays high until resume.
- R6: Bit r of `sr_cmd_o` pulses for one cycle, in the same cycle that row r's clock-enable falls. In staggered modes at most one bit is set.
- R7: A `resume_req_i` sampled in suspend raises all used CKE pins after that edge and clears `suspend_done_o`. `ready_o` returns EXIT_CYCLES edges later.
- R8: Per-row mode only: a row idle for `idle_limit_i` consecutive sampled cycles has its CKE dropped on the next edge. Its CKE rises on the first edge at which it is sampled busy.
- R9: In single-CKE and global-CKE modes, idle rows never lose CKE while running.
- R10: With `reg_dimm_i`=1, CKE stays high and no self-refresh command is issued. `suspend_done_o` rises on the edge that samples the request. Power-down is disabled.
- R11: With `edo_cbr_i`=1 (CAS-before-RAS refresh selected), suspend behaves as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| map_cfg_i | input | 1 | Topology bit: 1 selects single CKE0 |
| pwr_cfg_i | input | 1 | Topology bit: 1 selects global CKE when map_cfg_i is 0 |
| reg_dimm_i | input | 1 | Registered modules fitted |
| edo_cbr_i | input | 1 | CAS-before-RAS suspend refresh selected |
| suspend_req_i | input | 1 | Suspend request, level |
| resume_req_i | input | 1 | Resume request, sampled in suspend |
| row_idle_i | input | NUM_ROWS | Per-row idle indication |
| stagger_gap_i | input | GAP_W | Clocks between staggered row entries |
| idle_limit_i | input | IDLE_W | Idle clocks before power-down |
| cke_o | output | NUM_ROWS | Clock-enable pins |
| sr_cmd_o | output | NUM_ROWS | Per-row self-refresh command strobe |
| suspend_done_o | output | 1 | All rows in self-refresh |
| ready_o | output | 1 | Memory usable |

## Verification
The hardest cases to reach are the interaction between the per-row idle counters and the suspend sequencer, and the exact spacing of staggered entries when the gap is 0. The bench walks a table of topology, bypass and gap settings through full suspend and resume cycles. For each one it counts edges to completion and checks that strobes arrive in ascending order. Directed tests then hold single rows idle across the limit boundary, and hold all rows idle in topologies where power-down must stay off.

// File: rtl/sdram_sr_pkg.sv
package sdram_sr_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_ENTER, ST_SUSP, ST_EXIT} sr_state_e;
endpackage

// File: rtl/sr_mode_decode.sv
module sr_mode_decode (
  input  logic map_cfg_i,
  input  logic pwr_cfg_i,
  input  logic reg_dimm_i,
  input  logic edo_cbr_i,
  output logic stagger_o,
  output logic single_pin_o,
  output logic pd_en_o,
  output logic bypass_o
);
  always_comb begin
    stagger_o    = !map_cfg_i;
    single_pin_o = map_cfg_i || pwr_cfg_i;
    bypass_o     = reg_dimm_i || edo_cbr_i;
    pd_en_o      = !map_cfg_i && !pwr_cfg_i && !bypass_o;
  end
endmodule

// File: rtl/sr_row_pd.sv
module sr_row_pd #(
  parameter int IDLE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              pd_en_i,
  input  logic              idle_i,
  input  logic [IDLE_W-1:0] limit_i,
  input  logic              wake_i,
  input  logic              sleep_i,
  output logic              cke_o
);
  logic [IDLE_W-1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o    <= 1'b1;
      idle_cnt <= '0;
    end else if (sleep_i) begin
      cke_o    <= 1'b0;
      idle_cnt <= '0;
    end else if (wake_i) begin
      cke_o    <= 1'b1;
      idle_cnt <= '0;
    end else if (run_i) begin
      if (pd_en_i && idle_i) begin
        if (idle_cnt == limit_i) cke_o <= 1'b0;
        else                     idle_cnt <= idle_cnt + 1'b1;
      end else begin
        cke_o    <= 1'b1;
        idle_cnt <= '0;
      end
    end
  end

  // R9
  pd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !pd_en_i && !sleep_i) |=> cke_o);

  // R8
  wake_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !idle_i && !sleep_i) |=> cke_o);
endmodule

// File: rtl/sdram_suspend_ctl.sv
module sdram_suspend_ctl
  import sdram_sr_pkg::*;
#(
  parameter int NUM_ROWS    = 6,
  parameter int GAP_W       = 4,
  parameter int IDLE_W      = 4,
  parameter int EXIT_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                map_cfg_i,
  input  logic                pwr_cfg_i,
  input  logic                reg_dimm_i,
  input  logic                edo_cbr_i,
  input  logic                suspend_req_i,
  input  logic                resume_req_i,
  input  logic [NUM_ROWS-1:0] row_idle_i,
  input  logic [GAP_W-1:0]    stagger_gap_i,
  input  logic [IDLE_W-1:0]   idle_limit_i,
  output logic [NUM_ROWS-1:0] cke_o,
  output logic [NUM_ROWS-1:0] sr_cmd_o,
  output logic                suspend_done_o,
  output logic                ready_o
);
  localparam int PTR_W  = $clog2(NUM_ROWS + 1);
  localparam int EXIT_W = $clog2(EXIT_CYCLES + 1);
  localparam int CNT_W  = (EXIT_W > GAP_W) ? EXIT_W : GAP_W;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_ROWS);

  sr_state_e           state;
  logic [PTR_W-1:0]    ptr;
  logic [CNT_W-1:0]    cnt;
  logic [NUM_ROWS-1:0] row_cke, sleep_vec, sr_cmd_q;
  logic                done_q, wake_all, step;
  logic                stagger, single_pin, pd_en, bypass;
  logic [GAP_W-1:0]    gap_eff;

  sr_mode_decode u_dec (
    .map_cfg_i   (map_cfg_i),
    .pwr_cfg_i   (pwr_cfg_i),
    .reg_dimm_i  (reg_dimm_i),
    .edo_cbr_i   (edo_cbr_i),
    .stagger_o   (stagger),
    .single_pin_o(single_pin),
    .pd_en_o     (pd_en),
    .bypass_o    (bypass)
  );

  assign gap_eff  = (stagger_gap_i == '0) ? GAP_W'(1) : stagger_gap_i;
  assign wake_all = (state == ST_RUN && suspend_req_i) || (state == ST_SUSP && resume_req_i);
  assign step     = (state == ST_ENTER) && (ptr != LAST_PTR) && (cnt == '0);

  always_comb begin
    sleep_vec = '0;
    if (step) begin
      if (stagger) sleep_vec[ptr] = 1'b1;
      else         sleep_vec = '1;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    sr_row_pd #(.IDLE_W(IDLE_W)) u_row (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (state == ST_RUN),
      .pd_en_i(pd_en),
      .idle_i (row_idle_i[r]),
      .limit_i(idle_limit_i),
      .wake_i (wake_all),
      .sleep_i(sleep_vec[r]),
      .cke_o  (row_cke[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_RUN;
      ptr      <= '0;
      cnt      <= '0;
      sr_cmd_q <= '0;
      done_q   <= 1'b0;
    end else begin
      sr_cmd_q <= sleep_vec;
      unique case (state)
        ST_RUN: if (suspend_req_i) begin
          if (bypass) begin
            state  <= ST_SUSP;
            done_q <= 1'b1;
          end else begin
            state <= ST_ENTER;
            ptr   <= '0;
            cnt   <= '0;
          end
        end
        ST_ENTER: begin
          if (ptr == LAST_PTR) begin
            state  <= ST_SUSP;
            done_q <= 1'b1;
          end else if (step) begin
            ptr <= stagger ? ptr + 1'b1 : LAST_PTR;
            cnt <= CNT_W'(gap_eff - 1'b1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SUSP: if (resume_req_i) begin
          state  <= ST_EXIT;
          done_q <= 1'b0;
          cnt    <= CNT_W'(EXIT_CYCLES - 1);
        end
        ST_EXIT: begin
          if (cnt == '0) state <= ST_RUN;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // pin mapping per topology
  always_comb begin
    cke_o    = '0;
    cke_o[0] = single_pin ? |row_cke : row_cke[0];
    if (!single_pin) cke_o = row_cke;
  end

  assign sr_cmd_o       = sr_cmd_q;
  assign suspend_done_o = done_q;
  assign ready_o        = (state == ST_RUN);

  // R6
  strobe_cke_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_cmd_q & row_cke) == '0);
  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stagger && !bypass) |-> $onehot0(sr_cmd_q));
  // R5
  done_all_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_done_o && !bypass) |-> (row_cke == '0));
  // R7
  ready_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (&row_cke));
  // R10
  bypass_no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |-> (sr_cmd_q == '0 && (&row_cke)));
endmodule

// File: tb/sdram_suspend_ctl_tb.sv
module sdram_suspend_ctl_tb;
  localparam int NR = 6;
  localparam int EXITC = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic map_cfg, pwr_cfg, reg_dimm, edo_cbr, sus_req, res_req;
  logic [NR-1:0] row_idle;
  logic [3:0] gap, lim;
  logic [NR-1:0] cke, sr_cmd;
  logic done, ready;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sdram_suspend_ctl #(.NUM_ROWS(NR), .EXIT_CYCLES(EXITC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .map_cfg_i(map_cfg), .pwr_cfg_i(pwr_cfg),
    .reg_dimm_i(reg_dimm), .edo_cbr_i(edo_cbr), .suspend_req_i(sus_req),
    .resume_req_i(res_req), .row_idle_i(row_idle), .stagger_gap_i(gap),
    .idle_limit_i(lim), .cke_o(cke), .sr_cmd_o(sr_cmd),
    .suspend_done_o(done), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // {map, pwr, reg, cbr, gap[3:0]}
  localparam logic [7:0] VEC [7] = '{
    8'b0000_0010, 8'b1000_0010, 8'b1100_0011, 8'b0100_0011,
    8'b0010_0010, 8'b0101_0001, 8'b0000_0000
  };

  initial begin
    map_cfg = 0; pwr_cfg = 0; reg_dimm = 0; edo_cbr = 0;
    sus_req = 0; res_req = 0; row_idle = '0; gap = 4'd1; lim = 4'd3;
    #45 rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(cke == 6'h3F && ready && !done && sr_cmd == '0, "R1", {cke, ready, done}, {6'h3F, 2'b10});

    for (int v = 0; v < 7; v++) begin
      bit mm, pw, byp, stag, single;
      int n, exp_lat, lat, strobes, nxt;
      logic [NR-1:0] act_pat;
      {mm, pw, reg_dimm, edo_cbr, gap} = {VEC[v][7:4], VEC[v][3:0]};
      map_cfg = mm; pwr_cfg = pw;
      byp = reg_dimm || edo_cbr;
      stag = !mm;
      single = mm || pw;
      n = (gap == 0) ? 1 : int'(gap);
      exp_lat = byp ? 1 : (stag ? 3 + (NR - 1) * n : 3);
      act_pat = single ? 6'h01 : 6'h3F;
      sus_req = 1'b1;
      lat = 0; strobes = 0; nxt = 0;
      while (!done && lat < 200) begin
        tick(1);
        lat++;
        if (sr_cmd != '0) begin
          strobes++;
          if (stag) begin
            // R2 R4 ascending single strobes
            chk(sr_cmd == NR'(1) << nxt, "R2", sr_cmd, NR'(1) << nxt);
            nxt++;
          end else begin
            // R3 all rows at once
            chk(sr_cmd == '1, "R3", sr_cmd, 6'h3F);
          end
        end
      end
      sus_req = 1'b0;
      // R5 R10 R11
      chk(lat == exp_lat, byp ? (reg_dimm ? "R10" : "R11") : "R5", lat, exp_lat);
      chk(strobes == (byp ? 0 : (stag ? NR : 1)), byp ? "R10" : "R6", strobes, byp ? 0 : (stag ? NR : 1));
      chk(cke == (byp ? act_pat : 6'h00), single ? "R4" : "R2", cke, byp ? act_pat : 6'h00);
      tick(2);
      res_req = 1'b1;
      tick(1);
      res_req = 1'b0;
      // R7
      chk(cke == act_pat && !ready && !done, "R7", {cke, ready}, {act_pat, 1'b0});
      lat = 1;
      while (!ready && lat < 200) begin
        tick(1);
        lat++;
      end
      chk(lat == EXITC + 1, "R7", lat, EXITC + 1);
    end

    // R8 per-row power-down
    map_cfg = 0; pwr_cfg = 0; reg_dimm = 0; edo_cbr = 0; lim = 4'd3;
    row_idle = 6'b000100;
    tick(3);
    chk(cke == 6'h3F, "R8", cke, 6'h3F);
    tick(1);
    chk(cke == 6'h3B, "R8", cke, 6'h3B);
    row_idle = '0;
    tick(1);
    chk(cke == 6'h3F, "R8", cke, 6'h3F);

    // R9 global and single modes keep CKE up
    pwr_cfg = 1; row_idle = '1;
    tick(10);
    chk(cke == 6'h01, "R9", cke, 6'h01);
    map_cfg = 1; pwr_cfg = 0;
    tick(10);
    chk(cke == 6'h01, "R9", cke, 6'h01);

    // R10 registered: no power-down in per-row mode
    map_cfg = 0; reg_dimm = 1;
    tick(10);
    chk(cke == 6'h3F, "R10", cke, 6'h3F);
    row_idle = '0; reg_dimm = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule